// File: doc/BRIEF.md
# Low-Power PMIC Signalling Sequencer

This block drives the two control pins that tell an external power IC what the core is doing: a clock-request pin, and an off-mode pin that marks full power-down. When the core goes idle it sequences these pins, and when a wake event arrives it plays them back. All waits are counted in ticks of a 32 kHz timebase. The timebase is supplied as a one-cycle enable pulse, `tick_32k`, in the fast clock domain.

A small control register picks the target low-power state. The choices are retention, off or clock-stop sleep. For off, a second bit chooses between the off-mode pin and an I2C voltage command. When an I2C command is needed, the block raises a one-cycle request toward the I2C engine. The setup counts come in as tick counts:
- an oscillator setup time;
- a voltage offset;
- a voltage ramp time for I2C-signalled transitions.

The polarity of each pin is programmable. The block reports `ready` once the supply domain is fully back after a wake.

Top module: `lps_seq`

## Requirements
- R1: A control write with `ctl_mode` code 0, 1 or 2 selects retention, off or sleep and clears the other two. Code 3 clears all three. `auto_mode` shows the selection one-hot: bit 0 retention, bit 1 off, bit 2 sleep. After reset it reads 0.
- R2: While no low-power state is selected, `sleep_req` is ignored. `ready` stays high, both pins keep their active levels and `i2c_go` stays low.
- R3: A retention entry, or an off entry signalled over I2C, starts with a one-cycle `i2c_go`. `i2c_off` is 0 for retention and 1 for off. After `cnt_vret` further ticks only the clock-request pin goes inactive; the off-mode pin stays active.
- R4: An off entry signalled by pin makes both pins inactive one cycle after the request, with no `i2c_go`.
- R5: Waking from pin-signalled off works as follows:
  - the off-mode pin goes active first;
  - the clock-request pin goes active after the offset count;
  - `ready` rises after a further (clock setup − offset) ticks, taken as 0 when the offset is not smaller.
- R6: The offset count used is `cnt_voff`, raised to MIN_OFS_TICKS (16 by default) when it is smaller.
- R7: The clock setup count used is `cnt_clk`, or DEF_CLK_TICKS (328 by default) when `cnt_clk` is 0.
- R8: Waking from an I2C-signalled state does two things on the same cycle: the clock-request pin goes active and `i2c_go` pulses with `i2c_off` = 0. `ready` rises `cnt_vret` ticks later.
- R9: Sleep entry makes only the clock-request pin inactive, one cycle after the request. On wake that pin goes active and `ready` follows after the clock setup count.
- R10: A `wake_req` during an I2C entry wait aborts the entry. The clock-request pin never goes inactive, `i2c_go` pulses with `i2c_off` = 0, and `ready` rises `cnt_vret` ticks later.
- R11: Each pin carries its logical level when its polarity bit is 1 and the inverse when it is 0. A polarity change reaches the pin at the next clock edge. While `ready` is high both pins are at their active levels.
- R12: `ready` is high after reset and falls only in the cycle after an accepted `sleep_req`. `i2c_go` never lasts more than one cycle and is never high together with `ready`. If the off-mode pin is inactive, the clock-request pin is inactive too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k | input | 1 | One-cycle pulse per 32 kHz period |
| ctl_we | input | 1 | Control register write strobe |
| ctl_mode | input | 2 | 0 retention, 1 off, 2 sleep, 3 clear |
| ctl_off_pin | input | 1 | On write: 1 = off signalled by pin, 0 = by I2C |
| pol_clkreq | input | 1 | 1 = clock-request pin active high |
| pol_offmode | input | 1 | 1 = off-mode pin active high |
| cnt_clk | input | CW | Oscillator setup ticks (0 = default) |
| cnt_voff | input | CW | Voltage offset ticks |
| cnt_vret | input | CW | Voltage ramp ticks for I2C transitions |
| sleep_req | input | 1 | Core entering low power |
| wake_req | input | 1 | Wake event |
| clkreq_pin | output | 1 | Clock-request pin |
| offmode_pin | output | 1 | Off-mode pin |
| i2c_go | output | 1 | One-cycle I2C voltage command request |
| i2c_off | output | 1 | Command target: 1 off level, 0 on level |
| ready | output | 1 | Domain fully up |
| auto_mode | output | 3 | Selected state, one-hot |

## Verification
The bench builds the block with an 8-bit count width, DEF_CLK_TICKS = 20 and MIN_OFS_TICKS = 3. With these values, both the default clock setup and the offset floor are reached by small sweeps. The bench sweeps every clock-setup count from 0 to 8 against every offset from 0 to 6. This covers the default substitution, the floor, and the saturating case where the offset exceeds the clock setup. With a tick every four clocks, it measures exact tick counts between pin events for every I2C ramp count from 0 to 5, across all four polarity combinations.

// File: rtl/lps_pkg.sv
package lps_pkg;
  localparam logic [1:0] MODE_RET = 2'd0;
  localparam logic [1:0] MODE_OFF = 2'd1;
  localparam logic [1:0] MODE_SLP = 2'd2;
  localparam logic [1:0] MODE_CLR = 2'd3;

  typedef enum logic [2:0] {
    S_ACT, S_ENT, S_LOW, S_EXA, S_EXB
  } seq_st_e;

  typedef enum logic [1:0] {
    LK_RET, LK_OFF_I2C, LK_OFF_PIN, LK_SLP
  } lp_kind_e;
endpackage

// File: rtl/lps_modereg.sv
module lps_modereg
  import lps_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [1:0] code,
  input  logic       pin_sel_in,
  output logic [2:0] mode,
  output logic       pin_sel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= 3'b000;
      pin_sel <= 1'b0;
    end else if (we) begin
      pin_sel <= pin_sel_in;
      case (code)
        MODE_RET: mode <= 3'b001;
        MODE_OFF: mode <= 3'b010;
        MODE_SLP: mode <= 3'b100;
        default:  mode <= 3'b000;
      endcase
    end
  end
endmodule

// File: rtl/lps_tickcnt.sv
module lps_tickcnt #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  input  logic          tick,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (ld)                cnt <= ld_val;
    else if (tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/lps_pindrv.sv
module lps_pindrv #(
  parameter int NP = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NP-1:0] lvl_n,
  input  logic [NP-1:0] pol,
  output logic [NP-1:0] pin
);
  for (genvar i = 0; i < NP; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) pin[i] <= pol[i];
      else     pin[i] <= lvl_n[i] ~^ pol[i];
    end
  end
endmodule

// File: rtl/lps_seq.sv
module lps_seq
  import lps_pkg::*;
#(
  parameter int CW            = 12,
  parameter int DEF_CLK_TICKS = 328,
  parameter int MIN_OFS_TICKS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_32k,
  input  logic          ctl_we,
  input  logic [1:0]    ctl_mode,
  input  logic          ctl_off_pin,
  input  logic          pol_clkreq,
  input  logic          pol_offmode,
  input  logic [CW-1:0] cnt_clk,
  input  logic [CW-1:0] cnt_voff,
  input  logic [CW-1:0] cnt_vret,
  input  logic          sleep_req,
  input  logic          wake_req,
  output logic          clkreq_pin,
  output logic          offmode_pin,
  output logic          i2c_go,
  output logic          i2c_off,
  output logic          ready,
  output logic [2:0]    auto_mode
);
  localparam logic [CW-1:0] DEF_CLK = CW'(DEF_CLK_TICKS);
  localparam logic [CW-1:0] MIN_OFS = CW'(MIN_OFS_TICKS);

  logic          pin_sel;
  logic [CW-1:0] clk_eff, ofs_eff, set_eff;
  seq_st_e       st, st_n;
  lp_kind_e      kind, kind_n;
  logic          clk_on, clk_n, pwr_on, pwr_n;
  logic          rdy_n, go_n, off_n;
  logic          ld, zero;
  logic [CW-1:0] ld_val;
  logic [1:0]    pins;

  lps_modereg u_mode (
    .clk(clk), .rst(rst), .we(ctl_we), .code(ctl_mode),
    .pin_sel_in(ctl_off_pin), .mode(auto_mode), .pin_sel(pin_sel)
  );

  lps_tickcnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .ld(ld), .ld_val(ld_val),
    .tick(tick_32k), .zero(zero)
  );

  lps_pindrv #(.NP(2)) u_pins (
    .clk(clk), .rst(rst), .lvl_n({pwr_n, clk_n}),
    .pol({pol_offmode, pol_clkreq}), .pin(pins)
  );

  assign clkreq_pin  = pins[0];
  assign offmode_pin = pins[1];

  // effective counts: default clock setup, offset floor, saturating split
  assign clk_eff = (cnt_clk == '0) ? DEF_CLK : cnt_clk;
  assign ofs_eff = (cnt_voff < MIN_OFS) ? MIN_OFS : cnt_voff;
  assign set_eff = (clk_eff > ofs_eff) ? clk_eff - ofs_eff : '0;

  always_comb begin
    st_n   = st;
    kind_n = kind;
    clk_n  = clk_on;
    pwr_n  = pwr_on;
    rdy_n  = ready;
    go_n   = 1'b0;
    off_n  = i2c_off;
    ld     = 1'b0;
    ld_val = cnt_vret;
    case (st)
      S_ACT: begin
        if (sleep_req && auto_mode != 3'b000) begin
          rdy_n = 1'b0;
          if (auto_mode[2]) begin
            kind_n = LK_SLP;
            clk_n  = 1'b0;
            st_n   = S_LOW;
          end else if (auto_mode[1] && pin_sel) begin
            kind_n = LK_OFF_PIN;
            clk_n  = 1'b0;
            pwr_n  = 1'b0;
            st_n   = S_LOW;
          end else begin
            kind_n = auto_mode[1] ? LK_OFF_I2C : LK_RET;
            go_n   = 1'b1;
            off_n  = auto_mode[1];
            ld     = 1'b1;
            st_n   = S_ENT;
          end
        end
      end
      S_ENT: begin
        if (wake_req) begin
          go_n  = 1'b1;
          off_n = 1'b0;
          ld    = 1'b1;
          st_n  = S_EXB;
        end else if (zero) begin
          clk_n = 1'b0;
          st_n  = S_LOW;
        end
      end
      S_LOW: begin
        if (wake_req) begin
          case (kind)
            LK_OFF_PIN: begin
              pwr_n  = 1'b1;
              ld     = 1'b1;
              ld_val = ofs_eff;
              st_n   = S_EXA;
            end
            LK_SLP: begin
              clk_n  = 1'b1;
              ld     = 1'b1;
              ld_val = clk_eff;
              st_n   = S_EXB;
            end
            default: begin
              clk_n = 1'b1;
              go_n  = 1'b1;
              off_n = 1'b0;
              ld    = 1'b1;
              st_n  = S_EXB;
            end
          endcase
        end
      end
      S_EXA: begin
        if (zero) begin
          clk_n  = 1'b1;
          ld     = 1'b1;
          ld_val = set_eff;
          st_n   = S_EXB;
        end
      end
      S_EXB: begin
        if (zero) begin
          rdy_n = 1'b1;
          st_n  = S_ACT;
        end
      end
      default: st_n = S_ACT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_ACT;
      kind    <= LK_RET;
      clk_on  <= 1'b1;
      pwr_on  <= 1'b1;
      ready   <= 1'b1;
      i2c_go  <= 1'b0;
      i2c_off <= 1'b0;
    end else begin
      st      <= st_n;
      kind    <= kind_n;
      clk_on  <= clk_n;
      pwr_on  <= pwr_n;
      ready   <= rdy_n;
      i2c_go  <= go_n;
      i2c_off <= off_n;
    end
  end
endmodule

// File: rtl/lps_seq_chk.sv
module lps_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       ready,
  input logic       i2c_go,
  input logic       clkreq_pin,
  input logic       offmode_pin,
  input logic       pol_clkreq,
  input logic       pol_offmode,
  input logic       sleep_req,
  input logic [2:0] auto_mode
);
  // R1
  mode_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(auto_mode));

  // R11
  ready_pins_active_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> (clkreq_pin == $past(pol_clkreq)) && (offmode_pin == $past(pol_offmode)));

  // R12
  off_implies_clkoff_chk: assert property (@(posedge clk) disable iff (rst)
    (offmode_pin != $past(pol_offmode)) |-> (clkreq_pin != $past(pol_clkreq)));

  // R12
  go_single_chk: assert property (@(posedge clk) disable iff (rst)
    i2c_go |=> !i2c_go);

  // R12
  go_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    i2c_go |-> !ready);

  // R12
  ready_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> $past(sleep_req));
endmodule

bind lps_seq lps_seq_chk u_chk (
  .clk(clk), .rst(rst), .ready(ready), .i2c_go(i2c_go),
  .clkreq_pin(clkreq_pin), .offmode_pin(offmode_pin),
  .pol_clkreq(pol_clkreq), .pol_offmode(pol_offmode),
  .sleep_req(sleep_req), .auto_mode(auto_mode)
);

// File: tb/tb_lps_seq.sv
`timescale 1ns/1ps
module tb_lps_seq;
  localparam int CW = 8;
  localparam int DEFC = 20;
  localparam int MINO = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_32k = 1'b0;
  logic tick_q = 1'b0;
  logic ctl_we = 1'b0;
  logic [1:0] ctl_mode = 2'd3;
  logic ctl_off_pin = 1'b0;
  logic pol_clkreq = 1'b1;
  logic pol_offmode = 1'b0;
  logic [CW-1:0] cnt_clk = '0, cnt_voff = '0, cnt_vret = '0;
  logic sleep_req = 1'b0, wake_req = 1'b0;
  logic clkreq_pin, offmode_pin, i2c_go, i2c_off, ready;
  logic [2:0] auto_mode;

  int tests = 0;
  int fails = 0;
  logic [2:0] snap;
  int tdiv = 0;

  always #2.5 clk = ~clk;

  lps_seq #(.CW(CW), .DEF_CLK_TICKS(DEFC), .MIN_OFS_TICKS(MINO)) dut (
    .clk(clk), .rst(rst), .tick_32k(tick_32k), .ctl_we(ctl_we),
    .ctl_mode(ctl_mode), .ctl_off_pin(ctl_off_pin),
    .pol_clkreq(pol_clkreq), .pol_offmode(pol_offmode),
    .cnt_clk(cnt_clk), .cnt_voff(cnt_voff), .cnt_vret(cnt_vret),
    .sleep_req(sleep_req), .wake_req(wake_req),
    .clkreq_pin(clkreq_pin), .offmode_pin(offmode_pin),
    .i2c_go(i2c_go), .i2c_off(i2c_off), .ready(ready), .auto_mode(auto_mode)
  );

  // tick every fourth clock, changed away from the active edge
  always @(negedge clk) begin
    tdiv <= (tdiv + 1) % 4;
    tick_32k <= (tdiv == 2);
  end
  always @(posedge clk) tick_q <= tick_32k;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit lv(input bit logical, input bit pol);
    return pol ? logical : !logical;
  endfunction

  task automatic expect_st(input string tag, input bit ec, input bit eo,
                           input bit er, input bit eg);
    logic [3:0] a, e;
    a = {clkreq_pin, offmode_pin, ready, i2c_go};
    e = {lv(ec, pol_clkreq), lv(eo, pol_offmode), er, eg};
    chk(a === e, tag, int'(a), int'(e));
  endtask

  task automatic wait_event(output int nt);
    int n = 0;
    logic [2:0] cur;
    nt = -1;
    for (int g = 0; g < 3000; g++) begin
      @(negedge clk);
      cur = {clkreq_pin, offmode_pin, ready};
      if (cur !== snap || i2c_go === 1'b1) begin
        snap = cur;
        nt = n;
        return;
      end
      if (tick_q) n++;
    end
    chk(1'b0, "event watchdog", 0, 1);
  endtask

  task automatic pulse_sleep();
    sleep_req = 1'b1;
    @(posedge clk); #1;
    sleep_req = 1'b0;
  endtask

  task automatic pulse_wake();
    wake_req = 1'b1;
    @(posedge clk); #1;
    wake_req = 1'b0;
  endtask

  task automatic write_mode(input logic [1:0] code, input bit psel);
    ctl_mode = code; ctl_off_pin = psel; ctl_we = 1'b1;
    @(posedge clk); #1;
    ctl_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_pol(input bit pc, input bit po);
    pol_clkreq = pc; pol_offmode = po;
    @(negedge clk); @(negedge clk);
    snap = {clkreq_pin, offmode_pin, ready};
  endtask

  task automatic run_i2c(input int vr, input bit is_off);
    int nt;
    cnt_vret = CW'(vr);
    write_mode(is_off ? 2'd1 : 2'd0, 1'b0);
    pulse_sleep();
    wait_event(nt);
    expect_st("R3 entry start", 1, 1, 0, 1);
    chk(i2c_off === is_off, "R3 i2c_off level", int'(i2c_off), int'(is_off));
    wait_event(nt);
    chk(nt == vr, "R3 entry ticks", nt, vr);
    expect_st("R3 only clkreq drops", 0, 1, 0, 0);
    pulse_wake();
    wait_event(nt);
    expect_st("R8 exit start", 1, 1, 0, 1);
    chk(i2c_off === 1'b0, "R8 i2c_off on", int'(i2c_off), 0);
    wait_event(nt);
    chk(nt == vr, "R8 exit ticks", nt, vr);
    expect_st("R8 ready", 1, 1, 1, 0);
  endtask

  task automatic run_pin(input int c, input int v);
    int nt, ce, oe, se;
    ce = (c == 0) ? DEFC : c;
    oe = (v < MINO) ? MINO : v;
    se = (ce > oe) ? ce - oe : 0;
    cnt_clk = CW'(c); cnt_voff = CW'(v);
    pulse_sleep();
    wait_event(nt);
    expect_st("R4 both pins off", 0, 0, 0, 0);
    pulse_wake();
    wait_event(nt);
    expect_st("R5 offmode first", 0, 1, 0, 0);
    wait_event(nt);
    chk(nt == oe, "R6 offset ticks", nt, oe);
    expect_st("R5 clkreq second", 1, 1, 0, 0);
    wait_event(nt);
    chk(nt == se, "R5 setup ticks", nt, se);
    expect_st("R5 ready", 1, 1, 1, 0);
  endtask

  task automatic run_slp(input int c);
    int nt, ce;
    ce = (c == 0) ? DEFC : c;
    cnt_clk = CW'(c);
    pulse_sleep();
    wait_event(nt);
    expect_st("R9 sleep entry", 0, 1, 0, 0);
    pulse_wake();
    wait_event(nt);
    expect_st("R9 clkreq back", 1, 1, 0, 0);
    wait_event(nt);
    chk(nt == ce, "R7 clock setup ticks", nt, ce);
    expect_st("R9 ready", 1, 1, 1, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "global watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int nt;
    logic [2:0] em;
    bit quiet;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_st("R12 reset state", 1, 1, 1, 0);
    chk(auto_mode === 3'b000, "R1 reset mode", int'(auto_mode), 0);
    snap = {clkreq_pin, offmode_pin, ready};

    // R1 mode register one-hot selection
    for (int k = 0; k < 4; k++) begin
      write_mode(2'(k), 1'b0);
      em = (k < 3) ? 3'(1 << k) : 3'b000;
      chk(auto_mode === em, "R1 mode select", int'(auto_mode), int'(em));
    end

    // R2 sleep request ignored with no mode
    pulse_sleep();
    quiet = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if ({clkreq_pin, offmode_pin, ready} !== snap || i2c_go) quiet = 1'b0;
    end
    chk(quiet, "R2 request ignored", int'(quiet), 1);

    // R11 polarity on each pin
    for (int p = 0; p < 4; p++) begin
      set_pol(p[0], p[1]);
      expect_st("R11 idle polarity", 1, 1, 1, 0);
    end

    // R3 R8 retention and I2C off across ramp counts and polarities
    for (int vr = 0; vr < 6; vr++) begin
      set_pol(vr[0], vr[1]);
      run_i2c(vr, 1'b0);
    end
    for (int vr = 1; vr < 4; vr++) begin
      set_pol(vr[1], vr[0]);
      run_i2c(vr, 1'b1);
    end

    // R4 R5 R6 R7 pin-signalled off sweep
    set_pol(1'b1, 1'b0);
    write_mode(2'd1, 1'b1);
    for (int c = 0; c < 9; c++)
      for (int v = 0; v < 7; v++) begin
        if ((c + v) % 5 == 0) set_pol(c[0], v[0]);
        run_pin(c, v);
      end

    // R9 R7 sleep
    set_pol(1'b0, 1'b1);
    write_mode(2'd2, 1'b0);
    run_slp(0);
    run_slp(1);
    run_slp(7);

    // R10 abort during entry wait
    set_pol(1'b1, 1'b0);
    cnt_vret = CW'(6);
    write_mode(2'd0, 1'b0);
    pulse_sleep();
    wait_event(nt);
    expect_st("R10 entry start", 1, 1, 0, 1);
    @(negedge clk); @(negedge clk);
    snap = {clkreq_pin, offmode_pin, ready};
    pulse_wake();
    wait_event(nt);
    expect_st("R10 abort go", 1, 1, 0, 1);
    chk(i2c_off === 1'b0, "R10 abort on level", int'(i2c_off), 0);
    wait_event(nt);
    chk(nt == 6, "R10 abort ticks", nt, 6);
    expect_st("R10 ready, clkreq kept", 1, 1, 1, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule